// File: doc/BRIEF.md
# Single-Precision NaN Classifier and Selector

This block sits next to a single-precision arithmetic datapath and decides the NaN side of every result. It takes one or two 32-bit operands, reports the class of each operand on one-hot outputs, and tells the datapath whether the result must be a NaN. When it must, the block gives the exact NaN to return and says whether Invalid Operation has to be raised. It also drives an unordered flag for compare operations.

The datapath supplies three controls. One says whether the second operand takes part. One says that the operation is invalid by its own nature, such as zero times infinity or the root of a negative value. The third selects a copy or format-change mode, in which a NaN is carried across untouched. The block is purely combinational. It holds no state, and its outputs follow its inputs in the same cycle.

Top module: `nan_resolver`

## Requirements
- R1: Each class output is one-hot with bit 0 zero, bit 1 denormal, bit 2 normal, bit 3 infinity, bit 4 quiet NaN, bit 5 signaling NaN; both operands are always classified.
- R2: A value is a NaN when its exponent is all ones and its fraction is non-zero; it is signaling when fraction bit 22 is 0 and quiet when that bit is 1.
- R3: `unordered` is 1 exactly when operand A is a NaN, or when operand B takes part (`use_b`=1 and `copy_mode`=0) and is a NaN.
- R4: In arithmetic mode a signaling NaN operand raises `raise_invalid` and is returned with fraction bit 22 set and its sign and other bits unchanged.
- R5: When both operands are NaNs, a signaling one is chosen over a quiet one; between NaNs of the same kind, operand A is chosen.
- R6: A quiet NaN operand is returned bit-exact and raises no Invalid Operation, even when `op_invalid` is 1.
- R7: With `op_invalid`=1 and no NaN operand taking part, the result is the default NaN 32'h7FC00000 and `raise_invalid` is 1.
- R8: In copy mode a NaN in operand A is returned bit-exact, signaling or quiet, with `raise_invalid` 0; operand B and `op_invalid` have no effect.
- R9: With `use_b`=0, operand B has no effect on `nan_out`, `nan_val`, `raise_invalid` or `unordered`.
- R10: With no NaN operand taking part and no invalid condition, `nan_out` and `raise_invalid` are 0 and `nan_val` holds 32'h7FC00000.

Below is the port list for `nan_resolver`:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| use_b | input | 1 | Second operand takes part in the operation |
| op_invalid | input | 1 | Operation is invalid on non-NaN inputs |
| copy_mode | input | 1 | Copy or format change: NaNs pass unchanged |
| cls_a | output | 6 | One-hot class of op_a |
| cls_b | output | 6 | One-hot class of op_b |
| nan_out | output | 1 | Result must be a NaN |
| nan_val | output | 32 | NaN to return |
| raise_invalid | output | 1 | Invalid Operation must be raised |
| unordered | output | 1 | Compare result is unordered |

## Verification
The bound checker watches the one-hot form of both class outputs and the link between `unordered` and the NaN classes of the operands that take part. It also checks that an arithmetic-mode NaN result always carries the quiet bit and that copy mode never raises Invalid Operation. The choice of which NaN wins, the bit-exact preservation of payloads and signs, and the default NaN encoding can only be shown by the bench's directed scenarios. Those scenarios compare full 32-bit results against values worked out by hand.

// File: rtl/nanres_pkg.sv
// Shared definitions for the NaN resolver: class vector width and bit positions.
package nanres_pkg;
    localparam int CLS_W    = 6;
    localparam int CLS_ZERO = 0;
    localparam int CLS_DEN  = 1;
    localparam int CLS_NORM = 2;
    localparam int CLS_INF  = 3;
    localparam int CLS_QNAN = 4;
    localparam int CLS_SNAN = 5;
    typedef logic [CLS_W-1:0] fclass_t;
endpackage

// File: rtl/nanres_classify.sv
// nanres_classify: decodes one IEEE binary value into a one-hot class vector.
// Assumes sign in the top bit, then EXP_W exponent bits, then FRAC_W fraction bits.
// The quiet bit is the most significant fraction bit.
module nanres_classify
    import nanres_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int DW    = 1 + EXP_W + FRAC_W
) (
    input  logic [DW-1:0] val,
    output fclass_t       cls
);
    logic [EXP_W-1:0]  expf;
    logic [FRAC_W-1:0] frac;
    logic exp_max, exp_zero, frac_zero;

    // split the fields and find the exponent and fraction extremes
    always_comb begin
        expf      = val[DW-2 -: EXP_W];
        frac      = val[FRAC_W-1:0];
        exp_max   = &expf;
        exp_zero  = ~|expf;
        frac_zero = ~|frac;
    end

    // build the one-hot class vector
    always_comb begin
        cls           = '0;
        cls[CLS_ZERO] = exp_zero & frac_zero;
        cls[CLS_DEN]  = exp_zero & ~frac_zero;
        cls[CLS_NORM] = ~exp_zero & ~exp_max;
        cls[CLS_INF]  = exp_max & frac_zero;
        cls[CLS_QNAN] = exp_max & ~frac_zero & frac[FRAC_W-1];
        cls[CLS_SNAN] = exp_max & ~frac_zero & ~frac[FRAC_W-1];
    end
endmodule

// File: rtl/nanres_select.sv
// nanres_select: chooses the NaN result and the Invalid Operation flag.
// Priority in arithmetic mode: signaling A, signaling B, quiet A, quiet B,
// then the default NaN on an invalid operation. Copy mode passes A unchanged.
// Assumes the NaN class flags come from nanres_classify for the same operands.
module nanres_select #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int DW    = 1 + EXP_W + FRAC_W
) (
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    input  logic          a_q,
    input  logic          a_s,
    input  logic          b_q,
    input  logic          b_s,
    input  logic          use_b,
    input  logic          op_invalid,
    input  logic          copy_mode,
    output logic          nan_out,
    output logic [DW-1:0] nan_val,
    output logic          raise_invalid,
    output logic          unordered
);
    localparam logic [DW-1:0] QBIT    = DW'(1) << (FRAC_W-1);
    localparam logic [DW-1:0] DEF_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic b_on, a_nan, b_nan;

    // decide which operand NaNs take part
    always_comb begin
        b_on  = use_b & ~copy_mode;
        a_nan = a_q | a_s;
        b_nan = b_on & (b_q | b_s);
        unordered = a_nan | b_nan;
    end

    // pick the result NaN in priority order
    always_comb begin
        nan_out       = 1'b0;
        nan_val       = DEF_NAN;
        raise_invalid = 1'b0;
        if (copy_mode) begin
            if (a_nan) begin
                nan_out = 1'b1;
                nan_val = op_a;
            end
        end else if (a_s) begin
            nan_out       = 1'b1;
            nan_val       = op_a | QBIT;
            raise_invalid = 1'b1;
        end else if (b_on && b_s) begin
            nan_out       = 1'b1;
            nan_val       = op_b | QBIT;
            raise_invalid = 1'b1;
        end else if (a_q) begin
            nan_out = 1'b1;
            nan_val = op_a;
        end else if (b_on && b_q) begin
            nan_out = 1'b1;
            nan_val = op_b;
        end else if (op_invalid) begin
            nan_out       = 1'b1;
            raise_invalid = 1'b1;
        end
    end
endmodule

// File: rtl/nan_resolver.sv
// nan_resolver: classifies up to two single-precision operands and resolves
// the NaN result, Invalid Operation flag and unordered flag. Purely
// combinational; the arithmetic itself lives elsewhere in the datapath.
module nan_resolver
    import nanres_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int DW    = 1 + EXP_W + FRAC_W,
    localparam int N_OPS = 2
) (
    input  logic [DW-1:0]    op_a,
    input  logic [DW-1:0]    op_b,
    input  logic             use_b,
    input  logic             op_invalid,
    input  logic             copy_mode,
    output logic [CLS_W-1:0] cls_a,
    output logic [CLS_W-1:0] cls_b,
    output logic             nan_out,
    output logic [DW-1:0]    nan_val,
    output logic             raise_invalid,
    output logic             unordered
);
    logic [DW-1:0] ops  [N_OPS];
    fclass_t       clss [N_OPS];

    // gather operands into an array for the classifier bank
    always_comb begin
        ops[0] = op_a;
        ops[1] = op_b;
    end

    for (genvar i = 0; i < N_OPS; i++) begin : g_cls
        nanres_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .val (ops[i]),
            .cls (clss[i])
        );
    end

    // expose the class vectors
    always_comb begin
        cls_a = clss[0];
        cls_b = clss[1];
    end

    nanres_select #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_sel (
        .op_a          (op_a),
        .op_b          (op_b),
        .a_q           (clss[0][CLS_QNAN]),
        .a_s           (clss[0][CLS_SNAN]),
        .b_q           (clss[1][CLS_QNAN]),
        .b_s           (clss[1][CLS_SNAN]),
        .use_b         (use_b),
        .op_invalid    (op_invalid),
        .copy_mode     (copy_mode),
        .nan_out       (nan_out),
        .nan_val       (nan_val),
        .raise_invalid (raise_invalid),
        .unordered     (unordered)
    );
endmodule

// File: rtl/nanres_chk.sv
// nanres_chk: combinational property checker bound to nan_resolver.
// Each check is skipped while any input it reads is still unknown.
module nanres_chk #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int DW    = 1 + EXP_W + FRAC_W
) (
    input logic [DW-1:0] op_a,
    input logic [DW-1:0] op_b,
    input logic          use_b,
    input logic          op_invalid,
    input logic          copy_mode,
    input logic [5:0]    cls_a,
    input logic [5:0]    cls_b,
    input logic          nan_out,
    input logic [DW-1:0] nan_val,
    input logic          raise_invalid,
    input logic          unordered
);
    // evaluate every property whenever the ports move
    always_comb begin
        if (!$isunknown({op_a, op_b, use_b, op_invalid, copy_mode})) begin
            // R1
            cls_a_onehot_chk: assert ($countones(cls_a) == 1);
            // R1
            cls_b_onehot_chk: assert ($countones(cls_b) == 1);
            // R3
            unordered_chk: assert (unordered ==
                ((|cls_a[5:4]) | (use_b & ~copy_mode & (|cls_b[5:4]))));
            // R4
            quiet_result_chk: assert (copy_mode || !nan_out ||
                ((&nan_val[DW-2 -: EXP_W]) && nan_val[FRAC_W-1]));
            // R8
            copy_no_invalid_chk: assert (!copy_mode || !raise_invalid);
            // R10
            no_nan_no_flag_chk: assert (nan_out || !raise_invalid);
        end
    end
endmodule

bind nan_resolver nanres_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .op_a          (op_a),
    .op_b          (op_b),
    .use_b         (use_b),
    .op_invalid    (op_invalid),
    .copy_mode     (copy_mode),
    .cls_a         (cls_a),
    .cls_b         (cls_b),
    .nan_out       (nan_out),
    .nan_val       (nan_val),
    .raise_invalid (raise_invalid),
    .unordered     (unordered)
);

// File: tb/nan_resolver_bench.sv
// Directed bench for nan_resolver: one task per scenario, each checking its results.
module nan_resolver_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic [31:0] op_a = '0, op_b = '0;
    logic use_b = 1'b0, op_invalid = 1'b0, copy_mode = 1'b0;
    logic [5:0] cls_a, cls_b;
    logic nan_out, raise_invalid, unordered;
    logic [31:0] nan_val;

    int n_chk = 0, n_bad = 0;

    localparam logic [5:0] C_ZERO = 6'b000001, C_DEN = 6'b000010, C_NORM = 6'b000100,
                           C_INF = 6'b001000, C_QNAN = 6'b010000, C_SNAN = 6'b100000;
    localparam logic [31:0] DEFN = 32'h7FC00000;
    localparam logic [31:0] QA = 32'h7FC12345, SA = 32'hFF812345;
    localparam logic [31:0] QB = 32'hFFC00ABC, SB = 32'h7F800001;
    localparam logic [31:0] ONE = 32'h3F800000;

    nan_resolver u_nan_resolver (
        .op_a(op_a), .op_b(op_b), .use_b(use_b), .op_invalid(op_invalid),
        .copy_mode(copy_mode), .cls_a(cls_a), .cls_b(cls_b), .nan_out(nan_out),
        .nan_val(nan_val), .raise_invalid(raise_invalid), .unordered(unordered)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] a, input logic [31:0] b,
                         input logic ub, input logic inv, input logic cp);
        @(posedge clk);
        op_a = a; op_b = b; use_b = ub; op_invalid = inv; copy_mode = cp;
        @(negedge clk);
    endtask

    task automatic expect_res(input string req, input logic n, input logic [31:0] v,
                              input logic i, input logic u);
        chk(req, {31'd0, nan_out}, {31'd0, n});
        chk(req, nan_val, v);
        chk(req, {31'd0, raise_invalid}, {31'd0, i});
        chk(req, {31'd0, unordered}, {31'd0, u});
    endtask

    task automatic t_idle();   // R10
        apply(32'h0, 32'h0, 1'b1, 1'b0, 1'b0);
        chk("R1 zero a", {26'd0, cls_a}, {26'd0, C_ZERO});
        expect_res("R10 idle", 1'b0, DEFN, 1'b0, 1'b0);
        apply(ONE, 32'hC0000000, 1'b1, 1'b0, 1'b0);
        expect_res("R10 normals", 1'b0, DEFN, 1'b0, 1'b0);
    endtask

    task automatic t_classify();   // R1 R2
        logic [31:0] v [9];
        logic [5:0]  c [9];
        v[0] = 32'h80000000; c[0] = C_ZERO;
        v[1] = 32'h00000001; c[1] = C_DEN;
        v[2] = 32'h807FFFFF; c[2] = C_DEN;
        v[3] = 32'h00800000; c[3] = C_NORM;
        v[4] = 32'h7F7FFFFF; c[4] = C_NORM;
        v[5] = 32'hFF800000; c[5] = C_INF;
        v[6] = 32'h7FC00000; c[6] = C_QNAN;
        v[7] = 32'h7FBFFFFF; c[7] = C_SNAN;
        v[8] = SB;           c[8] = C_SNAN;
        for (int k = 0; k < 9; k++) begin
            apply(v[k], v[8-k], 1'b0, 1'b0, 1'b0);
            chk("R1 R2 class a", {26'd0, cls_a}, {26'd0, c[k]});
            chk("R1 R2 class b", {26'd0, cls_b}, {26'd0, c[8-k]});
        end
    endtask

    task automatic t_signaling();   // R4
        apply(SA, ONE, 1'b1, 1'b0, 1'b0);
        expect_res("R4 sNaN a", 1'b1, 32'hFFC12345, 1'b1, 1'b1);
        apply(ONE, SB, 1'b1, 1'b0, 1'b0);
        expect_res("R4 sNaN b", 1'b1, 32'h7FC00001, 1'b1, 1'b1);
    endtask

    task automatic t_priority();   // R5
        apply(QA, SB, 1'b1, 1'b0, 1'b0);
        expect_res("R5 qa sb", 1'b1, 32'h7FC00001, 1'b1, 1'b1);
        apply(SA, SB, 1'b1, 1'b0, 1'b0);
        expect_res("R5 sa sb", 1'b1, 32'hFFC12345, 1'b1, 1'b1);
        apply(QA, QB, 1'b1, 1'b0, 1'b0);
        expect_res("R5 qa qb", 1'b1, QA, 1'b0, 1'b1);
    endtask

    task automatic t_quiet();   // R6
        apply(ONE, QB, 1'b1, 1'b0, 1'b0);
        expect_res("R6 qb pass", 1'b1, QB, 1'b0, 1'b1);
        apply(QA, 32'h7F800000, 1'b1, 1'b1, 1'b0);
        expect_res("R6 qa with invalid", 1'b1, QA, 1'b0, 1'b1);
    endtask

    task automatic t_default();   // R7
        apply(32'h0, 32'h7F800000, 1'b1, 1'b1, 1'b0);
        expect_res("R7 default", 1'b1, DEFN, 1'b1, 1'b0);
        apply(32'hBF800000, QB, 1'b0, 1'b1, 1'b0);
        expect_res("R7 unary invalid", 1'b1, DEFN, 1'b1, 1'b0);
    endtask

    task automatic t_copy();   // R8
        apply(SA, SB, 1'b1, 1'b1, 1'b1);
        expect_res("R8 copy sNaN", 1'b1, SA, 1'b0, 1'b1);
        apply(QA, ONE, 1'b1, 1'b0, 1'b1);
        expect_res("R8 copy qNaN", 1'b1, QA, 1'b0, 1'b1);
        apply(ONE, SB, 1'b1, 1'b1, 1'b1);
        expect_res("R8 copy ignores b and invalid", 1'b0, DEFN, 1'b0, 1'b0);
    endtask

    task automatic t_unary();   // R9 R3
        apply(ONE, SB, 1'b0, 1'b0, 1'b0);
        expect_res("R9 R3 b unused", 1'b0, DEFN, 1'b0, 1'b0);
        apply(QA, SB, 1'b0, 1'b0, 1'b0);
        expect_res("R9 qa b unused", 1'b1, QA, 1'b0, 1'b1);
    endtask

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        t_idle();
        t_classify();
        t_signaling();
        t_priority();
        t_quiet();
        t_default();
        t_copy();
        t_unary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule